// File: doc/BRIEF.md
# USART Bit-Rate Clock Generator

This block produces the timing enables that a serial transmitter and receiver run on. A reloadable down-counter, loaded from a 12-bit divisor, emits a base tick once every divisor+1 system clock cycles. Four clocking modes are built on that tick: asynchronous with 16x oversampling, asynchronous with 8x oversampling (double speed), synchronous master, where the block drives a square serial clock on a pin, and synchronous slave, where it samples an external serial clock and turns its edges into enables.

Three configuration inputs choose the mode: a synchronous-select bit, a double-speed bit and the pin direction bit. They are captured into a mode register. A polarity input chooses which serial clock edge launches transmit data and which edge samples receive data. Framing, shifting and data buffering belong to the neighbouring blocks.

Top module: `usart_clkgen`

## Requirements
- R1: The registered mode is decoded from the inputs as follows: sync_mode=0 and dbl_speed=0 gives async 16x; sync_mode=0 and dbl_speed=1 gives async 8x; sync_mode=1 and clk_dir_out=1 gives synchronous master; sync_mode=1 and clk_dir_out=0 gives synchronous slave. A change of the inputs takes effect one clock later.
- R2: Reset selects async 16x mode, clears the divisor counter to zero and drives sclk_oe low. The counter is zero in the first cycle after reset, so the first base tick falls in that cycle.
- R3: When no divisor write occurs, base ticks come every divisor+1 cycles. In both async modes, rx_tick pulses on every base tick.
- R4: In async 16x mode, tx_tick pulses once every 16 base ticks, which is 16*(divisor+1) cycles, and only in a cycle that also has rx_tick.
- R5: In async 8x mode, tx_tick pulses once every 8 base ticks, which is 8*(divisor+1) cycles.
- R6: dbl_speed has no effect in synchronous mode. The master serial clock period is the same with dbl_speed at 0 and at 1.
- R7: In master mode, sclk_oe is 1. sclk_out is a square wave that toggles on each base tick, so it rises every 2*(divisor+1) cycles.
- R8: In both async modes and in slave mode, sclk_oe is 0 and sclk_out is 0.
- R9: A cycle with divisor_wr=1 loads the divisor into the counter at once and produces no base tick, even when the counter is zero. The next base tick then comes divisor+1 cycles after the write cycle.
- R10: In slave mode, sclk_in passes through two synchronizing flops and then an edge detector. A level change driven before clock edge k shows as a one-cycle edge pulse in the cycle after edge k+1. The external clock must run slower than a quarter of the system clock.
- R11: In synchronous mode with edge_pol=0, rx_tick marks the rising edge of the serial clock and tx_tick marks the falling edge. With edge_pol=1 the two are swapped. In master mode the tick falls in the cycle just before sclk_out changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 0 = asynchronous, 1 = synchronous |
| dbl_speed | input | 1 | 8x oversampling in async mode; ignored in sync mode |
| clk_dir_out | input | 1 | Serial clock pin direction in sync mode: 1 = output (master), 0 = input (slave) |
| edge_pol | input | 1 | Serial clock edge polarity for launch and sample |
| divisor | input | 12 | Baud divisor; the base tick period is divisor+1 cycles |
| divisor_wr | input | 1 | Write strobe; reloads the counter from divisor |
| sclk_in | input | 1 | External serial clock (slave mode) |
| sclk_out | output | 1 | Driven serial clock (master mode) |
| sclk_oe | output | 1 | Output enable for the serial clock pin |
| tx_tick | output | 1 | Transmit bit enable |
| rx_tick | output | 1 | Receive sample enable |

## Verification
A divisor write can land in the same cycle in which the counter reaches zero and would otherwise reload itself and tick. The bench waits in async mode until it sees rx_tick high, which shows the counter is at zero. In that same cycle it raises divisor_wr with a larger divisor and checks that rx_tick drops at once. It then checks that the next tick comes exactly new-divisor+1 cycles later, not at the old period.

// File: rtl/ucg_pkg.sv
package ucg_pkg;
  typedef enum logic [1:0] {
    UCG_ASYNC_X16   = 2'd0,
    UCG_ASYNC_X8    = 2'd1,
    UCG_SYNC_MASTER = 2'd2,
    UCG_SYNC_SLAVE  = 2'd3
  } ucg_mode_e;

  // Mode from the three configuration bits; double speed only matters when async
  function automatic ucg_mode_e ucg_decode(input logic sync_sel, input logic dbl,
                                           input logic dir_out);
    if (!sync_sel) return dbl ? UCG_ASYNC_X8 : UCG_ASYNC_X16;
    return dir_out ? UCG_SYNC_MASTER : UCG_SYNC_SLAVE;
  endfunction

  function automatic logic ucg_is_sync(input ucg_mode_e m);
    return (m == UCG_SYNC_MASTER) || (m == UCG_SYNC_SLAVE);
  endfunction

  // Oversampling prescaler mask: bit tick when all masked bits are set
  function automatic logic [3:0] ucg_rate_mask(input ucg_mode_e m);
    case (m)
      UCG_ASYNC_X16: return 4'hF;
      UCG_ASYNC_X8:  return 4'h7;
      default:       return 4'h0;
    endcase
  endfunction
endpackage

// File: rtl/ucg_baud_cnt.sv
module ucg_baud_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div,
  input  logic         load,
  output logic         tick,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt;

  // A write takes priority over the zero crossing
  assign tick  = (cnt == '0) && !load;
  assign cnt_o = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load || tick)  cnt <= div;
    else                    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/ucg_edge_sync.sv
module ucg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sreg;
  logic              level, prev;

  assign level = sreg[STAGES-1];
  assign rise  = level && !prev;
  assign fall  = !level && prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      prev <= 1'b0;
    end else begin
      sreg <= {sreg[STAGES-2:0], pin};
      prev <= level;
    end
  end
endmodule

// File: rtl/ucg_rate_div.sv
module ucg_rate_div #(
  parameter int PW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             base_tick,
  input  ucg_pkg::ucg_mode_e mode,
  output logic             bit_tick,
  output logic             mclk,
  output logic             mclk_rise,
  output logic             mclk_fall
);
  import ucg_pkg::*;

  logic [PW-1:0] pre;
  logic [PW-1:0] mask;
  logic          is_async, is_master;

  assign mask      = PW'(ucg_rate_mask(mode));
  assign is_async  = !ucg_is_sync(mode);
  assign is_master = (mode == UCG_SYNC_MASTER);

  assign bit_tick  = base_tick && is_async && ((pre & mask) == mask);
  assign mclk_rise = base_tick && is_master && !restart && !mclk;
  assign mclk_fall = base_tick && is_master && !restart &&  mclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      mclk <= 1'b0;
    end else begin
      if (restart)                    pre <= '0;
      else if (base_tick && is_async) pre <= pre + 1'b1;

      if (restart || !is_master) mclk <= 1'b0;
      else if (base_tick)        mclk <= ~mclk;
    end
  end
endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen #(
  parameter int DIV_W     = 12,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_mode,
  input  logic             dbl_speed,
  input  logic             clk_dir_out,
  input  logic             edge_pol,
  input  logic [DIV_W-1:0] divisor,
  input  logic             divisor_wr,
  input  logic             sclk_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  output logic             tx_tick,
  output logic             rx_tick
);
  import ucg_pkg::*;

  localparam int PRE_W = 4;

  ucg_mode_e        mode_d, mode_q;
  logic             mode_chg, restart;
  logic             base_tick, bit_tick;
  logic [DIV_W-1:0] baud_cnt;
  logic             mclk, mclk_rise, mclk_fall;
  logic             s_rise, s_fall;
  logic             edge_rise, edge_fall;

  assign mode_d   = ucg_decode(sync_mode, dbl_speed, clk_dir_out);
  assign mode_chg = (mode_d != mode_q);
  assign restart  = divisor_wr || mode_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= UCG_ASYNC_X16;
    else        mode_q <= mode_d;
  end

  ucg_baud_cnt #(.W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(divisor), .load(divisor_wr),
    .tick(base_tick), .cnt_o(baud_cnt)
  );

  ucg_rate_div #(.PW(PRE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .restart(restart), .base_tick(base_tick),
    .mode(mode_q), .bit_tick(bit_tick), .mclk(mclk),
    .mclk_rise(mclk_rise), .mclk_fall(mclk_fall)
  );

  ucg_edge_sync #(.STAGES(SYNC_STGS)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(sclk_in), .rise(s_rise), .fall(s_fall)
  );

  always_comb begin
    edge_rise = 1'b0;
    edge_fall = 1'b0;
    if (mode_q == UCG_SYNC_MASTER) begin
      edge_rise = mclk_rise;
      edge_fall = mclk_fall;
    end else if (mode_q == UCG_SYNC_SLAVE) begin
      edge_rise = s_rise;
      edge_fall = s_fall;
    end
  end

  assign sclk_oe  = (mode_q == UCG_SYNC_MASTER);
  assign sclk_out = sclk_oe && mclk;

  always_comb begin
    if (!ucg_is_sync(mode_q)) begin
      rx_tick = base_tick;
      tx_tick = bit_tick;
    end else begin
      rx_tick = edge_pol ? edge_fall : edge_rise;
      tx_tick = edge_pol ? edge_rise : edge_fall;
    end
  end
endmodule

// File: rtl/ucg_checker.sv
module ucg_checker #(
  parameter int DIV_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input ucg_pkg::ucg_mode_e mode_q,
  input logic               base_tick,
  input logic               restart,
  input logic               divisor_wr,
  input logic [DIV_W-1:0]   divisor,
  input logic [DIV_W-1:0]   baud_cnt,
  input logic               sclk_out,
  input logic               sclk_oe,
  input logic               tx_tick,
  input logic               rx_tick
);
  import ucg_pkg::*;

  // R8
  pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_oe |-> !sclk_out);

  // R9
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    divisor_wr |=> (baud_cnt == $past(divisor)));

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |=> (baud_cnt == $past(divisor)));

  // R4
  bit_in_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ucg_is_sync(mode_q) && tx_tick) |-> rx_tick);

  // R11
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ucg_is_sync(mode_q) |-> !(tx_tick && rx_tick));

  // R7
  sclk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && $past(sclk_oe) && !$stable(sclk_out)) |-> $past(base_tick || restart));
endmodule

bind usart_clkgen ucg_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .base_tick(base_tick),
  .restart(restart), .divisor_wr(divisor_wr), .divisor(divisor),
  .baud_cnt(baud_cnt), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
  .tx_tick(tx_tick), .rx_tick(rx_tick)
);

// File: tb/tb_usart_clkgen.sv
module tb_usart_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int D  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_mode = 0, dbl_speed = 0, clk_dir_out = 0, edge_pol = 0;
  logic [DW-1:0] divisor = DW'(D);
  logic divisor_wr = 0, sclk_in = 0;
  logic sclk_out, sclk_oe, tx_tick, rx_tick;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usart_clkgen dut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .dbl_speed(dbl_speed),
    .clk_dir_out(clk_dir_out), .edge_pol(edge_pol), .divisor(divisor),
    .divisor_wr(divisor_wr), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .tx_tick(tx_tick), .rx_tick(rx_tick)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic pick(input int which, input logic prev_sclk);
    case (which)
      0: return tx_tick;
      1: return rx_tick;
      default: return sclk_out && !prev_sclk;
    endcase
  endfunction

  // Cycles between two consecutive events, skipping the first interval
  task automatic measure(input int which, output int n);
    logic prev = sclk_out;
    int seen = 0, cnt = 0;
    n = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (seen > 0) cnt++;
      if (pick(which, prev)) begin
        seen++;
        if (seen == 3) begin n = cnt; break; end
        cnt = 0;
      end
      prev = sclk_out;
    end
  endtask

  task automatic set_mode(input logic s, input logic d, input logic dir);
    @(negedge clk);
    sync_mode = s; dbl_speed = d; clk_dir_out = dir;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    check("R2", "sclk_oe after reset", sclk_oe, 0);
    check("R2", "sclk_out after reset", sclk_out, 0);
    check("R2", "tick from zeroed counter", rx_tick, 1);
    @(negedge clk); #1;
    check("R2", "no tick after reload", rx_tick, 0);
  endtask

  task automatic t_async;
    int n;
    set_mode(0, 0, 0);
    measure(1, n); check("R3", "rx_tick interval", n, D+1);
    measure(0, n); check("R4", "tx_tick interval x16", n, 16*(D+1));
    check("R8", "sclk_oe in async", sclk_oe, 0);
    set_mode(0, 1, 0);
    measure(0, n); check("R5", "tx_tick interval x8", n, 8*(D+1));
    measure(1, n); check("R1", "rx_tick interval x8", n, D+1);
    check("R8", "sclk_out in async", sclk_out, 0);
  endtask

  task automatic t_write_conflict;
    int n = 0;
    set_mode(0, 0, 0);
    for (int i = 0; i < 100 && !rx_tick; i++) begin @(negedge clk); #1; end
    divisor = DW'(9); divisor_wr = 1; #1;
    check("R9", "tick suppressed by write", rx_tick, 0);
    @(negedge clk); divisor_wr = 0;
    for (int i = 1; i < 100; i++) begin
      #1;
      if (rx_tick) begin n = i; break; end
      @(negedge clk);
    end
    check("R9", "first tick after write", n, 10);
    @(negedge clk); divisor = DW'(D); divisor_wr = 1;
    @(negedge clk); divisor_wr = 0;
  endtask

  task automatic t_master;
    int n;
    logic prev;
    set_mode(1, 0, 1);
    check("R7", "sclk_oe in master", sclk_oe, 1);
    measure(2, n); check("R7", "sclk_out period", n, 2*(D+1));
    dbl_speed = 1;
    measure(2, n); check("R6", "period with dbl_speed", n, 2*(D+1));
    dbl_speed = 0;
    edge_pol = 0;
    for (int i = 0; i < 100 && !rx_tick; i++) begin @(negedge clk); #1; end
    prev = sclk_out;
    @(negedge clk); #1;
    check("R11", "pol0 rx_tick before rise", {prev, sclk_out}, 2'b01);
    edge_pol = 1; #1;
    for (int i = 0; i < 100 && !rx_tick; i++) begin @(negedge clk); #1; end
    prev = sclk_out;
    @(negedge clk); #1;
    check("R11", "pol1 rx_tick before fall", {prev, sclk_out}, 2'b10);
    edge_pol = 0;
  endtask

  task automatic slave_edge(input logic lvl, input string req, input int exp_rx, input int exp_tx);
    @(negedge clk); sclk_in = lvl;
    @(negedge clk); #1;
    check(req, "no pulse after one edge", {rx_tick, tx_tick}, 0);
    @(negedge clk); #1;
    check(req, "rx_tick on synced edge", rx_tick, exp_rx);
    check(req, "tx_tick on synced edge", tx_tick, exp_tx);
    @(negedge clk); #1;
    check(req, "pulse lasts one cycle", {rx_tick, tx_tick}, 0);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_slave;
    int cnt = 0;
    set_mode(1, 0, 0);
    sclk_in = 0;
    repeat (4) @(negedge clk);
    check("R8", "sclk_oe in slave", sclk_oe, 0);
    edge_pol = 0;
    slave_edge(1, "R10", 1, 0);
    slave_edge(0, "R10", 0, 1);
    edge_pol = 1;
    slave_edge(1, "R11", 0, 1);
    slave_edge(0, "R11", 1, 0);
    edge_pol = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); #1; cnt += int'(rx_tick) + int'(tx_tick); end
    check("R10", "no ticks from base counter in slave", cnt, 0);
  endtask

  initial begin
    t_reset;
    t_async;
    t_write_conflict;
    t_master;
    t_slave;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule